// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block supplies the fetch stage with its next fetch address every cycle. A small direct-mapped table keeps, for each recently taken branch, a tag taken from the branch's own address and the target that branch last jumped to. The current fetch address is the lookup key. When a valid entry's tag matches, the stored target is offered as the next fetch address. Otherwise the fetch address advances by one instruction.

When a branch resolves further down the pipeline, the resolution port reports several things: the branch address, whether it was taken, its real target, and the prediction that fetch made for it. A taken branch writes or refreshes its entry, so the table always holds the last-seen target. A not-taken branch that owns an entry clears that entry. If the prediction was wrong in direction or in target, the block raises a redirect one cycle later, together with the correct address. Fetch uses it to restart and to mark the younger wrong-path instructions invalid.

Top module: `btb_predictor`

## Requirements
- R1: Reset clears every entry, so after reset every lookup misses (predTaken = 0).
- R2: On a miss, nextPc = fetchPc + 4 and predTaken = 0, in the same cycle as fetchPc.
- R3: The table index is fetchPc[5:2] and the tag is fetchPc[31:6]. A hit needs a valid entry with an equal tag, so an address with the same index but another tag misses.
- R4: A taken resolution (resValid = 1, resTaken = 1) writes its entry. From the next cycle, a lookup of resPc hits, with predTaken = 1 and nextPc = resTarget.
- R5: A later taken resolution of the same branch with another target replaces the stored target (last-seen target).
- R6: A not-taken resolution whose resPc has a valid entry with a matching tag invalidates that entry. A not-taken resolution whose tag does not match leaves the resident entry unchanged.
- R7: When a resolution and a lookup use the same index in the same cycle, the lookup returns the contents held before the write.
- R8: redirect is high in the cycle after a resolution in either of two cases: resTaken differs from resPredTaken, or both are taken and resTarget differs from resPredTarget. In that cycle, redirectPc = resTarget if taken, else resPc + 4.
- R9: redirect stays low after a correctly predicted resolution and after any cycle with resValid = 0, and the table is not written when resValid = 0.
- R10: A loop back-edge that is taken three times and then falls through redirects exactly twice: on its first and its last execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchPc | input | 32 | Current fetch address (lookup key) |
| nextPc | output | 32 | Predicted next fetch address |
| predTaken | output | 1 | Lookup hit: nextPc is a stored target |
| resValid | input | 1 | A branch resolves this cycle |
| resPc | input | 32 | Address of the resolving branch |
| resTarget | input | 32 | Real target of the resolving branch |
| resTaken | input | 1 | Resolving branch was taken |
| resPredTaken | input | 1 | predTaken recorded when the branch was fetched |
| resPredTarget | input | 32 | nextPc recorded when the branch was fetched |
| redirect | output | 1 | Flush wrong-path work and restart fetch |
| redirectPc | output | 32 | Correct restart address while redirect is high |

## Verification
The lookup outputs nextPc and predTaken are combinational. They are sampled 1 ns after inputs change on the falling edge, within the same cycle. Table writes and invalidations take effect on the following rising edge, so their results are checked through a lookup in a later vector. redirect and redirectPc come from one register stage and are sampled just after the rising edge that ends the resolution cycle. The same-cycle write and lookup case is checked at the combinational sample, before that edge.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // Strobes the control logic hands to the datapath for one resolution.
  typedef struct packed {
    logic wrEn;       // record taken branch
    logic invEn;      // drop entry of not-taken branch
    logic redirEn;    // prediction was wrong
    logic redirTaken; // restart at target (1) or fall-through (0)
  } btbStrobe_t;
endpackage

// File: rtl/btb_ctrl.sv
module btb_ctrl #(
  parameter int ADDR_W = 32
) (
  input  logic              resValid,
  input  logic              resTaken,
  input  logic              resPredTaken,
  input  logic [ADDR_W-1:0] resTarget,
  input  logic [ADDR_W-1:0] resPredTarget,
  input  logic              updHit,
  output btb_pkg::btbStrobe_t strobe
);
  logic dirWrong;
  logic tgtWrong;

  always_comb begin
    dirWrong = resTaken ^ resPredTaken;
    tgtWrong = resTaken & resPredTaken & (resTarget != resPredTarget);
    strobe.wrEn       = resValid & resTaken;
    strobe.invEn      = resValid & ~resTaken & updHit;
    strobe.redirEn    = resValid & (dirWrong | tgtWrong);
    strobe.redirTaken = resTaken;
  end
endmodule

// File: rtl/btb_datapath.sv
module btb_datapath #(
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 16,
  parameter int INST_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic [ADDR_W-1:0] resPc,
  input  logic [ADDR_W-1:0] resTarget,
  input  btb_pkg::btbStrobe_t strobe,
  output logic              updHit,
  output logic [ADDR_W-1:0] nextPc,
  output logic              predTaken,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirectPc
);
  localparam int OFF_W = $clog2(INST_BYTES);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

  logic              tblValid  [ENTRIES];
  logic [TAG_W-1:0]  tblTag    [ENTRIES];
  logic [ADDR_W-1:0] tblTarget [ENTRIES];

  logic [IDX_W-1:0] fIdx, uIdx;
  logic [TAG_W-1:0] fTag, uTag;

  assign fIdx = fetchPc[OFF_W +: IDX_W];
  assign fTag = fetchPc[ADDR_W-1 -: TAG_W];
  assign uIdx = resPc[OFF_W +: IDX_W];
  assign uTag = resPc[ADDR_W-1 -: TAG_W];

  // Lookup reads the registered contents, so a same-cycle update is not seen.
  always_comb begin
    predTaken = tblValid[fIdx] && (tblTag[fIdx] == fTag);
    nextPc    = predTaken ? tblTarget[fIdx] : fetchPc + STEP;
    updHit    = tblValid[uIdx] && (tblTag[uIdx] == uTag);
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic sel;
    assign sel = (uIdx == IDX_W'(e));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    tblValid[e] <= 1'b0;
      else if (sel && strobe.wrEn)  tblValid[e] <= 1'b1;
      else if (sel && strobe.invEn) tblValid[e] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (sel && strobe.wrEn) begin
        tblTag[e]    <= uTag;
        tblTarget[e] <= resTarget;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      redirect   <= 1'b0;
      redirectPc <= '0;
    end else begin
      redirect   <= strobe.redirEn;
      redirectPc <= strobe.redirTaken ? resTarget : resPc + STEP;
    end
  end

  // R4: a recorded branch is resident with its tag on the next cycle
  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> (tblValid[$past(uIdx)] && tblTag[$past(uIdx)] == $past(uTag)));

  // R6: an invalidated entry is gone on the next cycle
  assert_invalidate_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.invEn |=> !tblValid[$past(uIdx)]);
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 16,
  parameter int INST_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] fetchPc,
  output logic [ADDR_W-1:0] nextPc,
  output logic              predTaken,
  input  logic              resValid,
  input  logic [ADDR_W-1:0] resPc,
  input  logic [ADDR_W-1:0] resTarget,
  input  logic              resTaken,
  input  logic              resPredTaken,
  input  logic [ADDR_W-1:0] resPredTarget,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirectPc
);
  btb_pkg::btbStrobe_t strobe;
  logic updHit;

  btb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .resValid(resValid), .resTaken(resTaken), .resPredTaken(resPredTaken),
    .resTarget(resTarget), .resPredTarget(resPredTarget),
    .updHit(updHit), .strobe(strobe)
  );

  btb_datapath #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .INST_BYTES(INST_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .resPc(resPc),
    .resTarget(resTarget), .strobe(strobe), .updHit(updHit),
    .nextPc(nextPc), .predTaken(predTaken),
    .redirect(redirect), .redirectPc(redirectPc)
  );

  // R8: a redirect only ever follows a resolution
  assert_redirect_follows_res_R8: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> $past(resValid));

  // R9: a correct prediction never redirects
  assert_no_redirect_on_hit_R9: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resTaken == resPredTaken && (!resTaken || resTarget == resPredTarget))
      |=> !redirect);
endmodule

// File: tb/tb_btb_predictor.sv
module tb_btb_predictor;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] fetchPc;
    logic        rv;
    logic [31:0] rPc;
    logic [31:0] rTgt;
    logic        rTk;
    logic        rPtk;
    logic [31:0] rPtg;
    logic [31:0] expNext;
    logic        expPt;
    logic        expRedir;
    logic [31:0] expRedirPc;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    // R2 miss after reset
    '{32'h1004, 1'b0, 32'h0,    32'h0,    1'b0, 1'b0, 32'h0,    32'h1008, 1'b0, 1'b0, 32'h0,    8'd2},
    // R8 unpredicted taken branch redirects to target
    '{32'h3000, 1'b1, 32'h1004, 32'h2000, 1'b1, 1'b0, 32'h0,    32'h3004, 1'b0, 1'b1, 32'h2000, 8'd8},
    // R4 entry now hits
    '{32'h1004, 1'b0, 32'h0,    32'h0,    1'b0, 1'b0, 32'h0,    32'h2000, 1'b1, 1'b0, 32'h0,    8'd4},
    // R3 same index, other tag misses
    '{32'h1044, 1'b0, 32'h0,    32'h0,    1'b0, 1'b0, 32'h0,    32'h1048, 1'b0, 1'b0, 32'h0,    8'd3},
    // R9 correct prediction, no redirect
    '{32'h1004, 1'b1, 32'h1004, 32'h2000, 1'b1, 1'b1, 32'h2000, 32'h2000, 1'b1, 1'b0, 32'h0,    8'd9},
    // R7 same-cycle update returns old target; R8 target mismatch redirects
    '{32'h1004, 1'b1, 32'h1004, 32'h2800, 1'b1, 1'b1, 32'h2000, 32'h2000, 1'b1, 1'b1, 32'h2800, 8'd7},
    // R5 new target stored
    '{32'h1004, 1'b0, 32'h0,    32'h0,    1'b0, 1'b0, 32'h0,    32'h2800, 1'b1, 1'b0, 32'h0,    8'd5},
    // R6 not-taken with other tag
    '{32'h1004, 1'b1, 32'h1044, 32'h0,    1'b0, 1'b0, 32'h0,    32'h2800, 1'b1, 1'b0, 32'h0,    8'd6},
    // R6 resident entry untouched
    '{32'h1004, 1'b0, 32'h0,    32'h0,    1'b0, 1'b0, 32'h0,    32'h2800, 1'b1, 1'b0, 32'h0,    8'd6},
    // R8 predicted taken, resolved not-taken: redirect to fall-through
    '{32'h5000, 1'b1, 32'h1004, 32'h0,    1'b0, 1'b1, 32'h2800, 32'h5004, 1'b0, 1'b1, 32'h1008, 8'd8},
    // R6 entry invalidated
    '{32'h1004, 1'b0, 32'h0,    32'h0,    1'b0, 1'b0, 32'h0,    32'h1008, 1'b0, 1'b0, 32'h0,    8'd6},
    // R9 resValid low: no redirect
    '{32'h1004, 1'b0, 32'h1004, 32'h2000, 1'b1, 1'b0, 32'h0,    32'h1008, 1'b0, 1'b0, 32'h0,    8'd9},
    // R9 resValid low: no write
    '{32'h1004, 1'b0, 32'h0,    32'h0,    1'b0, 1'b0, 32'h0,    32'h1008, 1'b0, 1'b0, 32'h0,    8'd9}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] fetchPc = '0, resPc = '0, resTarget = '0, resPredTarget = '0;
  logic resValid = 1'b0, resTaken = 1'b0, resPredTaken = 1'b0;
  logic [31:0] nextPc, redirectPc;
  logic predTaken, redirect;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  btb_predictor dut (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .nextPc(nextPc), .predTaken(predTaken),
    .resValid(resValid), .resPc(resPc), .resTarget(resTarget), .resTaken(resTaken),
    .resPredTaken(resPredTaken), .resPredTarget(resPredTarget),
    .redirect(redirect), .redirectPc(redirectPc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idleRes();
    resValid = 1'b0; resTaken = 1'b0; resPredTaken = 1'b0;
    resPc = '0; resTarget = '0; resPredTarget = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state
    @(negedge clk); fetchPc = 32'h1004; #1;
    check("R1 predTaken", {31'b0, predTaken}, 32'h0);
    check("R1 redirect", {31'b0, redirect}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      fetchPc = VECS[i].fetchPc; resValid = VECS[i].rv; resPc = VECS[i].rPc;
      resTarget = VECS[i].rTgt; resTaken = VECS[i].rTk;
      resPredTaken = VECS[i].rPtk; resPredTarget = VECS[i].rPtg;
      #1;
      check($sformatf("R%0d vec%0d nextPc", VECS[i].req, i), nextPc, VECS[i].expNext);
      check($sformatf("R%0d vec%0d predTaken", VECS[i].req, i), {31'b0, predTaken}, {31'b0, VECS[i].expPt});
      @(posedge clk); #1;
      check($sformatf("R%0d vec%0d redirect", VECS[i].req, i), {31'b0, redirect}, {31'b0, VECS[i].expRedir});
      if (VECS[i].expRedir)
        check($sformatf("R%0d vec%0d redirectPc", VECS[i].req, i), redirectPc, VECS[i].expRedirPc);
    end

    // R1: reset in mid-run clears a resident entry
    @(negedge clk); idleRes(); resValid = 1'b1; resPc = 32'h1004; resTarget = 32'h2000; resTaken = 1'b1;
    @(negedge clk); idleRes(); fetchPc = 32'h1004; #1;
    check("R1 entry present before reset", {31'b0, predTaken}, 32'h1);
    rstN = 1'b0; #2;
    check("R1 miss during reset", {31'b0, predTaken}, 32'h0);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk); #1;
    check("R1 miss after reset", {31'b0, predTaken}, 32'h0);
    check("R1 nextPc after reset", nextPc, 32'h1008);

    // R10: loop back-edge taken three times then falling through
    begin
      int redirCount = 0;
      for (int it = 0; it < 4; it++) begin
        logic p;
        logic [31:0] pt;
        @(negedge clk); idleRes(); fetchPc = 32'h1100; #1;
        p = predTaken; pt = nextPc;
        @(negedge clk);
        resValid = 1'b1; resPc = 32'h1100; resTarget = 32'h10C0; resTaken = (it < 3);
        resPredTaken = p; resPredTarget = pt; fetchPc = 32'h0;
        @(posedge clk); #1;
        if (redirect) redirCount++;
      end
      check("R10 loop redirect count", 32'(redirCount), 32'd2);
    end
    @(negedge clk); idleRes();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule